// File: doc/BRIEF.md
# Mode-Selectable Modulus Counter

A three-bit synchronous binary up-counter whose cycle length is chosen at run time by one control input. With the control low the counter runs through four states and wraps; with it high the counter runs through all eight states and wraps. Every state bit shares one clock and moves on its falling edge.

The next state is formed as a set of per-bit toggle enables, one for each bit, so the register maps directly onto toggle flip-flops. A terminal-count flag marks the last state of whichever cycle is selected. It can be used to pace a slower event or to feed a divider. The mode input is read on the same falling edge that moves the count, so a change of mode takes effect on the next transition.

Top module: `mode_mod_counter`

## Requirements
- R1: While rst_ni is low, count_o is 000 at once, without waiting for a clock edge, whatever mode_i is; tc_o is then 0.
- R2: count_o changes only on a falling edge of clk_i; across a rising edge it holds its value.
- R3: With mode_i = 0 (short mode), the count out of reset runs 000, 001, 010, 011 and then back to 000.
- R4: With mode_i = 1 (full mode), the count runs 000 to 111 in ascending binary order and wraps from 111 to 000.
- R5: With mode_i = 0 and the count anywhere in 100 to 111, the next falling edge loads 000.
- R6: mode_i is read at the falling edge that updates the count: switching to 1 while the count is 011 gives 100 next, and switching to 0 while the count is above 011 gives 000 next.
- R7: tc_o is 1 exactly when the count is 011 with mode_i = 0, or 111 with mode_i = 1; it is 0 otherwise.
- R8: A count bit changes at a falling edge only when its toggle enable was set; in full mode bit i toggles exactly when all bits below i are 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; state moves on its falling edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 1 | 0 selects the four-state cycle, 1 the eight-state cycle |
| count_o | output | 3 | Present count |
| tc_o | output | 1 | Terminal count of the selected cycle |

## Verification
The assertions watch, on every falling edge, the wrap from the short cycle's last state, the single step in full mode, the forced clear out of the upper half in short mode, the terminal flag always preceding a return to zero, and that no bit moves without its toggle enable. What they cannot show is the whole ordered sequence from reset, the immediate effect of reset between edges, the hold across rising edges, and the exact edge at which a mode change first counts; the bench's reference model covers those by driving mode switches at chosen states and an asynchronous reset mid-run.

// File: rtl/mmc_pkg.sv
package mmc_pkg;
  localparam int unsigned CNT_W = 3;

  typedef enum logic {
    MODE_SHORT = 1'b0,
    MODE_FULL  = 1'b1
  } mode_e;
endpackage

// File: rtl/mmc_toggle_gen.sv
module mmc_toggle_gen #(
  parameter int unsigned WIDTH = mmc_pkg::CNT_W
) (
  input  logic             mode_i,
  input  logic [WIDTH-1:0] q_i,
  output logic [WIDTH-1:0] tgl_o
);
  localparam int unsigned MSB = WIDTH - 1;

  logic [WIDTH:0] carry;

  assign carry[0] = 1'b1;
  for (genvar i = 0; i < WIDTH; i++) begin : g_carry
    assign carry[i+1] = carry[i] & q_i[i];
  end

  always_comb begin
    tgl_o = carry[WIDTH-1:0];
    if (mmc_pkg::mode_e'(mode_i) == mmc_pkg::MODE_SHORT) begin
      if (q_i[MSB]) tgl_o = q_i;       // out of range: clear every set bit
      else          tgl_o[MSB] = 1'b0; // short wrap leaves top bit at 0
    end
  end
endmodule

// File: rtl/mmc_tff_bank.sv
module mmc_tff_bank #(
  parameter int unsigned WIDTH = mmc_pkg::CNT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] tgl_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic bit_q;

    always_ff @(negedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       bit_q <= 1'b0;
      else if (tgl_i[i]) bit_q <= ~bit_q;
    end

    assign q_o[i] = bit_q;

    assert_bit_needs_tgl_R8: assert property (@(negedge clk_i) disable iff (!rst_ni)
      !tgl_i[i] |=> (q_o[i] == $past(q_o[i])))
      else $error("bit %0d moved without toggle enable", i);
  end
endmodule

// File: rtl/mmc_tc_decode.sv
module mmc_tc_decode #(
  parameter int unsigned WIDTH = mmc_pkg::CNT_W
) (
  input  logic             mode_i,
  input  logic [WIDTH-1:0] q_i,
  output logic             tc_o
);
  localparam logic [WIDTH-1:0] SHORT_LAST = {1'b0, {(WIDTH-1){1'b1}}};

  always_comb begin
    if (mmc_pkg::mode_e'(mode_i) == mmc_pkg::MODE_FULL) tc_o = &q_i;
    else                                                tc_o = (q_i == SHORT_LAST);
  end
endmodule

// File: rtl/mode_mod_counter.sv
module mode_mod_counter #(
  parameter int unsigned WIDTH = mmc_pkg::CNT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mode_i,
  output logic [WIDTH-1:0] count_o,
  output logic             tc_o
);
  localparam int unsigned     MSB        = WIDTH - 1;
  localparam logic [WIDTH-1:0] SHORT_LAST = {1'b0, {(WIDTH-1){1'b1}}};

  logic [WIDTH-1:0] q;
  logic [WIDTH-1:0] tgl;

  mmc_toggle_gen #(.WIDTH(WIDTH)) i_toggle_gen (
    .mode_i (mode_i),
    .q_i    (q),
    .tgl_o  (tgl)
  );

  mmc_tff_bank #(.WIDTH(WIDTH)) i_tff_bank (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tgl_i  (tgl),
    .q_o    (q)
  );

  mmc_tc_decode #(.WIDTH(WIDTH)) i_tc_decode (
    .mode_i (mode_i),
    .q_i    (q),
    .tc_o   (tc_o)
  );

  assign count_o = q;

  assert_short_wrap_R3: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (!mode_i && q == SHORT_LAST) |=> (q == '0))
    else $error("short cycle did not wrap");

  assert_short_stays_low_R3: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (!mode_i && !q[MSB]) |=> !q[MSB])
    else $error("short cycle left lower half");

  assert_full_step_R4: assert property (@(negedge clk_i) disable iff (!rst_ni)
    mode_i |=> (q == WIDTH'($past(q) + 1'b1)))
    else $error("full cycle did not step by one");

  assert_upper_clear_R5: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (!mode_i && q[MSB]) |=> (q == '0))
    else $error("upper state not cleared in short mode");

  assert_tc_then_zero_R7: assert property (@(negedge clk_i) disable iff (!rst_ni)
    tc_o |=> (q == '0))
    else $error("terminal count not followed by zero");
endmodule

// File: tb/test_mode_mod_counter.sv
module test_mode_mod_counter;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       mode_i = 1'b0;
  logic [2:0] count_o;
  logic       tc_o;

  int errors = 0;
  int checks = 0;
  int exp_cnt = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  mode_mod_counter i_mode_mod_counter (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .mode_i  (mode_i),
    .count_o (count_o),
    .tc_o    (tc_o)
  );

  function automatic int next_cnt(int c, bit m);
    if (m) return (c + 1) % 8;
    if (c >= 4) return 0;
    return (c + 1) % 4;
  endfunction

  function automatic bit exp_tc(int c, bit m);
    return m ? (c == 7) : (c == 3);
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Set mode now (just after a rising edge); the falling edge ahead uses it.
  task automatic step(bit m, string tag);
    int held;
    mode_i = m;
    exp_cnt = next_cnt(exp_cnt, m);
    @(posedge clk_i);
    held = count_o;
    #2;
    chk({tag, " count"}, count_o, exp_cnt);
    chk("R2 hold over rising edge", count_o, held);
    chk("R7 terminal flag", tc_o, exp_tc(exp_cnt, m));
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    #2;
    chk("R1 reset count", count_o, 0);
    chk("R1 reset flag", tc_o, 0);
    mode_i = 1'b1;
    @(posedge clk_i); #2;
    chk("R1 reset ignores mode", count_o, 0);
    rst_ni = 1'b1;
    exp_cnt = 0;

    for (int k = 0; k < 9; k++) step(1'b0, "R3 short sequence");
    // now at 1; go to 3 then switch to full
    step(1'b0, "R3 short sequence");
    step(1'b0, "R3 short sequence");
    step(1'b1, "R6 switch to full at 011");
    for (int k = 0; k < 12; k++) step(1'b1, "R4 full sequence");
    // now at 0; climb to 6 then drop to short
    for (int k = 0; k < 6; k++) step(1'b1, "R4 full sequence");
    step(1'b0, "R5 clear from 110");
    for (int k = 0; k < 5; k++) step(1'b1, "R4 full sequence");
    step(1'b0, "R5 clear from 101");
    for (int k = 0; k < 4; k++) step(1'b1, "R4 full sequence");
    step(1'b0, "R6 switch to short at 100");
    for (int k = 0; k < 7; k++) step(1'b1, "R4 full sequence");
    step(1'b0, "R5 clear from 111");
    step(1'b0, "R3 short sequence");

    // asynchronous reset in mid-run, away from any edge
    for (int k = 0; k < 5; k++) step(1'b1, "R4 full sequence");
    #3;
    rst_ni = 1'b0;
    #1;
    chk("R1 async reset count", count_o, 0);
    exp_cnt = 0;
    @(posedge clk_i); #2;
    chk("R1 reset holds", count_o, 0);
    rst_ni = 1'b1;
    for (int k = 0; k < 8; k++) step(1'b1, "R8 full toggles");
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (200000) @(posedge clk_i);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule